// File: doc/BRIEF.md
# PIO Timing Clock Converter

This block turns a pair of ATA PIO mode numbers, one for the master drive and one for the slave drive on a shared channel, into the packed timing bytes that a disk controller's cycle-timing registers expect. The bus clock frequency is an input in whole MHz. For each drive the block looks up the address-setup, active-pulse and full-cycle durations in nanoseconds. It then turns the setup time, the active time and the remaining recovery time into clock counts, rounding up. Each count is clamped to the range the register fields can hold.

A request begins with a one-cycle `start` pulse. The inputs must stay stable until `done`. The conversions share one multiplier and divider that work bit-serially, so a request takes a few hundred clocks. When the request finishes, `done` pulses for one cycle. At that point two per-drive cycle bytes and one shared miscellaneous byte are valid. They hold their values until the next request completes. The address-setup field is common to both drives, so it carries the longer of the two requirements. Every count is stored minus a fixed bias.

Top module: `pio_timing_conv`

## Requirements
- R1: A duration of T ns at F MHz becomes the integer quotient (T*F + 999) / 1000 clocks, before clamping.
- R2: The recovery count of a drive is converted from its cycle time minus its setup time minus its active time.
- R3: Address counts are clamped to 1..4, data counts to 1..16 and recovery counts to 2..17. A count of 0, for example at 0 MHz, clamps up to the minimum.
- R4: The mode code 15 marks a drive as absent. That drive uses address 1, data 1 and recovery 2, so its cycle byte is 0x00.
- R5: The shared address count is the larger of the two drives' clamped address counts.
- R6: Each cycle byte holds (data - 1) in bits 7:4 and (recovery - 2) in bits 3:0.
- R7: The misc byte holds `prefetch_en` in bit 6 and (shared address - 1) in bits 5:4. Bits 2:1 hold (ready delay - 2), with the ready delay fixed at 2 so the field is 0. Bits 7, 3 and 0 are 0.
- R8: Modes 0 to 4 use the (setup, active, cycle) times (70,165,600), (50,125,383), (30,100,240), (30,80,180) and (25,70,120) ns. Modes 5 to 14 are treated as mode 0.
- R9: `busy` rises on the clock edge that samples `start` while idle, and falls on the edge where `done` rises. `done` is high for exactly one cycle per accepted request. A `start` pulse while busy is ignored. The output bytes change only on the edge where `done` rises.
- R10: After reset, `busy`, `done` and all three output bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse |
| bus_mhz | input | MHZ_W | Bus clock frequency in MHz |
| mode_m | input | MODE_W | PIO mode of the master drive (15 = absent) |
| mode_s | input | MODE_W | PIO mode of the slave drive (15 = absent) |
| prefetch_en | input | 1 | Read-prefetch enable copied into the misc byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| cycle_m | output | 8 | Packed cycle byte for the master drive |
| cycle_s | output | 8 | Packed cycle byte for the slave drive |
| misc | output | 8 | Packed shared address/prefetch byte |

## Verification
The corner cases that are hardest to reach are the clamp limits. Standard modes at ordinary bus speeds never go past the top of any range. The bench therefore drives extreme bus frequencies: 255 MHz pushes every count above its maximum, and 0 and 1 MHz pull recovery below its minimum. It combines these with mixed master and slave modes, so that the shared address field has to take the slave's value in some cases and the master's in others. It also pulses `start` in the middle of a request, to show that a second request is not queued and that `done` fires only once.

// File: rtl/pio_conv_pkg.sv
package pio_conv_pkg;
   localparam int NS_W = 10;
   localparam int NUM_DRV = 2;
   localparam int NUM_KIND = 3;
   localparam int ADDR_MIN = 1;
   localparam int ADDR_MAX = 4;
   localparam int DATA_MIN = 1;
   localparam int DATA_MAX = 16;
   localparam int REC_MIN = 2;
   localparam int REC_MAX = 17;
   localparam int TOP_MODE = 4;

   typedef struct packed {
      logic [NS_W-1:0] setup;
      logic [NS_W-1:0] active;
      logic [NS_W-1:0] cycle;
   } pio_times_t;

   typedef enum logic [1:0] {
      K_ADDR = 2'd0,
      K_DATA = 2'd1,
      K_REC  = 2'd2
   } conv_kind_t;

   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction
endpackage

// File: rtl/pio_mode_rom.sv
module pio_mode_rom
   import pio_conv_pkg::*;
#(
   parameter int MODE_W      = 4,
   parameter int ABSENT_CODE = 15
) (
   input  logic [MODE_W-1:0] mode,
   output pio_times_t        times,
   output logic              absent
);
   logic [MODE_W-1:0] eff;

   always_comb begin
      absent = (mode == MODE_W'(ABSENT_CODE));
      eff    = (int'(mode) > TOP_MODE) ? '0 : mode;
      unique case (int'(eff))
         1:       times = '{setup: NS_W'(50), active: NS_W'(125), cycle: NS_W'(383)};
         2:       times = '{setup: NS_W'(30), active: NS_W'(100), cycle: NS_W'(240)};
         3:       times = '{setup: NS_W'(30), active: NS_W'(80),  cycle: NS_W'(180)};
         4:       times = '{setup: NS_W'(25), active: NS_W'(70),  cycle: NS_W'(120)};
         default: times = '{setup: NS_W'(70), active: NS_W'(165), cycle: NS_W'(600)};
      endcase
   end
endmodule

// File: rtl/pio_ns2clk.sv
module pio_ns2clk #(
   parameter int NS_W    = 10,
   parameter int MHZ_W   = 8,
   parameter int DIVISOR = 1000,
   parameter int CNT_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NS_W-1:0]  time_ns,
   input  logic [MHZ_W-1:0] mhz,
   output logic             done,
   output logic [CNT_W-1:0] count
);
   localparam int PROD_W = NS_W + MHZ_W + 1;
   localparam int REM_W  = $clog2(DIVISOR) + 1;
   localparam int STEP_W = $clog2(PROD_W + 1);
   localparam logic [PROD_W-1:0] ROUND_ADD = PROD_W'(DIVISOR - 1);
   localparam logic [REM_W:0]    DIV_K     = (REM_W + 1)'(DIVISOR);

   generate
      if (DIVISOR < 2) begin : g_bad_div
         $error("pio_ns2clk: DIVISOR must be at least 2");
      end
      if (PROD_W <= CNT_W) begin : g_bad_cnt
         $error("pio_ns2clk: CNT_W must be narrower than the product");
      end
   endgenerate

   typedef enum logic [1:0] {C_IDLE, C_MUL, C_RND, C_DIV} cstate_t;

   cstate_t           st;
   logic [PROD_W-1:0] mcand;
   logic [MHZ_W-1:0]  mplier;
   logic [PROD_W-1:0] acc;
   logic [REM_W-1:0]  rem;
   logic [STEP_W-1:0] step;

   logic [REM_W:0]    trial;
   logic              fits;
   logic [REM_W:0]    diff;
   logic [PROD_W-1:0] q_next;

   always_comb begin
      trial  = {rem, acc[PROD_W-1]};
      fits   = (trial >= DIV_K);
      diff   = trial - DIV_K;
      q_next = {acc[PROD_W-2:0], fits};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= C_IDLE;
         mcand  <= '0;
         mplier <= '0;
         acc    <= '0;
         rem    <= '0;
         step   <= '0;
         done   <= 1'b0;
         count  <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            C_IDLE: begin
               if (start) begin
                  mcand  <= PROD_W'(time_ns);
                  mplier <= mhz;
                  acc    <= '0;
                  step   <= STEP_W'(MHZ_W);
                  st     <= C_MUL;
               end
            end
            C_MUL: begin
               if (mplier[0]) acc <= acc + mcand;
               mcand  <= mcand << 1;
               mplier <= mplier >> 1;
               step   <= step - 1'b1;
               if (step == STEP_W'(1)) st <= C_RND;
            end
            C_RND: begin
               acc  <= acc + ROUND_ADD;
               rem  <= '0;
               step <= STEP_W'(PROD_W);
               st   <= C_DIV;
            end
            C_DIV: begin
               acc  <= q_next;
               rem  <= fits ? diff[REM_W-1:0] : trial[REM_W-1:0];
               step <= step - 1'b1;
               if (step == STEP_W'(1)) begin
                  done  <= 1'b1;
                  count <= (|q_next[PROD_W-1:CNT_W]) ? '1 : q_next[CNT_W-1:0];
                  st    <= C_IDLE;
               end
            end
            default: st <= C_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pio_clamp_pack.sv
module pio_clamp_pack
   import pio_conv_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic [CNT_W-1:0] raw_addr,
   input  logic [CNT_W-1:0] raw_data,
   input  logic [CNT_W-1:0] raw_rec,
   input  logic             absent,
   output logic [2:0]       addr_clk,
   output logic [7:0]       cyc_byte
);
   int a_c, d_c, r_c;

   always_comb begin
      if (absent) begin
         a_c = ADDR_MIN;
         d_c = DATA_MIN;
         r_c = REC_MIN;
      end else begin
         a_c = clamp_int(int'(raw_addr), ADDR_MIN, ADDR_MAX);
         d_c = clamp_int(int'(raw_data), DATA_MIN, DATA_MAX);
         r_c = clamp_int(int'(raw_rec),  REC_MIN,  REC_MAX);
      end
      addr_clk = 3'(a_c);
      cyc_byte = {4'(d_c - DATA_MIN), 4'(r_c - REC_MIN)};
   end
endmodule

// File: rtl/pio_timing_conv.sv
module pio_timing_conv
   import pio_conv_pkg::*;
#(
   parameter int MHZ_W       = 8,
   parameter int MODE_W      = 4,
   parameter int ABSENT_CODE = 15,
   parameter int DIVISOR     = 1000,
   parameter int CNT_W       = 8,
   parameter int DRDY_CLK    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MHZ_W-1:0]  bus_mhz,
   input  logic [MODE_W-1:0] mode_m,
   input  logic [MODE_W-1:0] mode_s,
   input  logic              prefetch_en,
   output logic              busy,
   output logic              done,
   output logic [7:0]        cycle_m,
   output logic [7:0]        cycle_s,
   output logic [7:0]        misc
);
   localparam int LAST_KIND = NUM_KIND - 1;

   generate
      if (DRDY_CLK < 2 || DRDY_CLK > 5) begin : g_bad_drdy
         $error("pio_timing_conv: DRDY_CLK must be 2..5");
      end
      if (ABSENT_CODE <= TOP_MODE || ABSENT_CODE >= (1 << MODE_W)) begin : g_bad_abs
         $error("pio_timing_conv: ABSENT_CODE must be an unused mode code");
      end
   endgenerate

   typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT, T_PACK} tstate_t;

   tstate_t           st;
   logic [MHZ_W-1:0]  mhz_q;
   logic              pf_q;
   logic [MODE_W-1:0] mode_q [NUM_DRV];
   logic              drv_q;
   conv_kind_t        kind_q;
   logic              cv_start;
   logic              cv_done;
   logic [CNT_W-1:0]  cv_count;
   logic [NS_W-1:0]   cv_time;
   logic [CNT_W-1:0]  raw_q  [NUM_DRV][NUM_KIND];
   pio_times_t        t_drv  [NUM_DRV];
   logic              ab_drv [NUM_DRV];
   logic [2:0]        a_pk   [NUM_DRV];
   logic [7:0]        c_pk   [NUM_DRV];
   logic [2:0]        ax;

   generate
      for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
         pio_mode_rom #(.MODE_W(MODE_W), .ABSENT_CODE(ABSENT_CODE)) u_rom (
            .mode   (mode_q[d]),
            .times  (t_drv[d]),
            .absent (ab_drv[d])
         );
         pio_clamp_pack #(.CNT_W(CNT_W)) u_pack (
            .raw_addr (raw_q[d][K_ADDR]),
            .raw_data (raw_q[d][K_DATA]),
            .raw_rec  (raw_q[d][K_REC]),
            .absent   (ab_drv[d]),
            .addr_clk (a_pk[d]),
            .cyc_byte (c_pk[d])
         );
      end
   endgenerate

   always_comb begin
      unique case (kind_q)
         K_ADDR:  cv_time = t_drv[drv_q].setup;
         K_DATA:  cv_time = t_drv[drv_q].active;
         default: cv_time = t_drv[drv_q].cycle - t_drv[drv_q].setup - t_drv[drv_q].active;
      endcase
      ax = (a_pk[0] > a_pk[1]) ? a_pk[0] : a_pk[1];
   end

   pio_ns2clk #(.NS_W(NS_W), .MHZ_W(MHZ_W), .DIVISOR(DIVISOR), .CNT_W(CNT_W)) u_conv (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (cv_start),
      .time_ns (cv_time),
      .mhz     (mhz_q),
      .done    (cv_done),
      .count   (cv_count)
   );

   assign busy = (st != T_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= T_IDLE;
         mhz_q    <= '0;
         pf_q     <= 1'b0;
         drv_q    <= 1'b0;
         kind_q   <= K_ADDR;
         cv_start <= 1'b0;
         done     <= 1'b0;
         cycle_m  <= '0;
         cycle_s  <= '0;
         misc     <= '0;
         for (int d = 0; d < NUM_DRV; d++) begin
            mode_q[d] <= '0;
            for (int k = 0; k < NUM_KIND; k++) raw_q[d][k] <= '0;
         end
      end else begin
         done     <= 1'b0;
         cv_start <= 1'b0;
         unique case (st)
            T_IDLE: begin
               if (start) begin
                  mhz_q     <= bus_mhz;
                  pf_q      <= prefetch_en;
                  mode_q[0] <= mode_m;
                  mode_q[1] <= mode_s;
                  drv_q     <= 1'b0;
                  kind_q    <= K_ADDR;
                  st        <= T_ISSUE;
               end
            end
            T_ISSUE: begin
               cv_start <= 1'b1;
               st       <= T_WAIT;
            end
            T_WAIT: begin
               if (cv_done) begin
                  raw_q[drv_q][kind_q] <= cv_count;
                  if (int'(kind_q) == LAST_KIND) begin
                     kind_q <= K_ADDR;
                     if (drv_q == 1'b1) st <= T_PACK;
                     else begin
                        drv_q <= 1'b1;
                        st    <= T_ISSUE;
                     end
                  end else begin
                     kind_q <= conv_kind_t'(kind_q + 2'd1);
                     st     <= T_ISSUE;
                  end
               end
            end
            T_PACK: begin
               cycle_m <= c_pk[0];
               cycle_s <= c_pk[1];
               misc    <= {1'b0, pf_q, 2'(ax - 3'd1), 1'b0, 2'(DRDY_CLK - 2), 1'b0};
               done    <= 1'b1;
               st      <= T_IDLE;
            end
            default: st <= T_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pio_timing_conv_chk.sv
module pio_timing_conv_chk #(
   parameter int MHZ_W       = 8,
   parameter int MODE_W      = 4,
   parameter int ABSENT_CODE = 15,
   parameter int DRDY_CLK    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [MHZ_W-1:0]  bus_mhz,
   input logic [MODE_W-1:0] mode_m,
   input logic [MODE_W-1:0] mode_s,
   input logic              prefetch_en,
   input logic              busy,
   input logic              done,
   input logic [7:0]        cycle_m,
   input logic [7:0]        cycle_s,
   input logic [7:0]        misc
);
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R9
   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R9
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({cycle_m, cycle_s, misc})); // R9
   AST_MISC_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (misc[7] == 1'b0 && misc[3] == 1'b0 && misc[0] == 1'b0
                && misc[2:1] == 2'(DRDY_CLK - 2))); // R7
   AST_PREFETCH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (misc[6] == prefetch_en)); // R7
   AST_ABSENT_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_m == MODE_W'(ABSENT_CODE)) |-> (cycle_m == 8'h00)); // R4
   AST_ABSENT_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_s == MODE_W'(ABSENT_CODE)) |-> (cycle_s == 8'h00)); // R4
   AST_BOTH_ABSENT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_m == MODE_W'(ABSENT_CODE) && mode_s == MODE_W'(ABSENT_CODE))
      |-> (misc[5:4] == 2'b00)); // R5
endmodule

bind pio_timing_conv pio_timing_conv_chk #(
   .MHZ_W(MHZ_W), .MODE_W(MODE_W), .ABSENT_CODE(ABSENT_CODE), .DRDY_CLK(DRDY_CLK)
) u_chk (.*);

// File: tb/sim_pio_timing_conv.sv
module sim_pio_timing_conv;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] bus_mhz = '0;
   logic [3:0] mode_m = '0;
   logic [3:0] mode_s = '0;
   logic       prefetch_en = 1'b0;
   logic       busy, done;
   logic [7:0] cycle_m, cycle_s, misc;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit pending = 0;
   bit in_reset = 1;
   logic [7:0] exp_m = '0, exp_s = '0, exp_x = '0;
   logic [7:0] hold_m = '0, hold_s = '0, hold_x = '0;

   always #4 clk = ~clk;

   pio_timing_conv u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .bus_mhz(bus_mhz),
      .mode_m(mode_m), .mode_s(mode_s), .prefetch_en(prefetch_en),
      .busy(busy), .done(done), .cycle_m(cycle_m), .cycle_s(cycle_s), .misc(misc)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
      end
   endtask

   function automatic int ceil_clk(input int t, input int f);
      return (t * f + 999) / 1000;
   endfunction

   function automatic int lim(input int v, input int lo, input int hi);
      return (v < lo) ? lo : ((v > hi) ? hi : v);
   endfunction

   // R8: timing table, out-of-range modes fall back to mode 0; R4: code 15 absent
   task automatic drive_counts(input int mode, input int f, output int a, output int d, output int r);
      int su[5] = '{70, 50, 30, 30, 25};
      int ac[5] = '{165, 125, 100, 80, 70};
      int cy[5] = '{600, 383, 240, 180, 120};
      int m;
      if (mode == 15) begin
         a = 1; d = 1; r = 2;
      end else begin
         m = (mode > 4) ? 0 : mode;
         a = lim(ceil_clk(su[m], f), 1, 4);                      // R1 R3
         d = lim(ceil_clk(ac[m], f), 1, 16);
         r = lim(ceil_clk(cy[m] - su[m] - ac[m], f), 2, 17);     // R2
      end
   endtask

   task automatic model(input int f, input int mm, input int ms, input bit pf);
      int am, dm, rm, as_, ds, rs, ax;
      drive_counts(mm, f, am, dm, rm);
      drive_counts(ms, f, as_, ds, rs);
      ax = (am > as_) ? am : as_;                                // R5
      exp_m = 8'(((dm - 1) << 4) | (rm - 2));                    // R6
      exp_s = 8'(((ds - 1) << 4) | (rs - 2));
      exp_x = 8'((int'(pf) << 6) | ((ax - 1) << 4));             // R7
   endtask

   // per-clock comparison against the behavioural model
   always @(negedge clk) begin
      cycles++;
      if (in_reset) begin
         check(busy == 1'b0 && done == 1'b0, "R10", "reset busy/done", {busy, done}, 0);
         check(cycle_m == 0 && cycle_s == 0 && misc == 0, "R10", "reset bytes",
               {cycle_m, cycle_s, misc}, 0);
      end else begin
         if (done) begin
            check(pending, "R9", "done without request", int'(done), 0);
            check(cycle_m == exp_m, "R6", "master cycle byte", cycle_m, exp_m);
            check(cycle_s == exp_s, "R6", "slave cycle byte", cycle_s, exp_s);
            check(misc == exp_x, "R7", "misc byte", misc, exp_x);
            hold_m = exp_m; hold_s = exp_s; hold_x = exp_x;
            pending = 0;
         end else begin
            check(cycle_m == hold_m && cycle_s == hold_s && misc == hold_x, "R9",
                  "bytes held", {cycle_m, cycle_s, misc}, {hold_m, hold_s, hold_x});
         end
         check(busy == (pending && !done), "R9", "busy flag", int'(busy), int'(pending && !done));
      end
      if (cycles > 150000) begin
         failures++;
         $display("FAIL R9 watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic run(input int f, input int mm, input int ms, input bit pf, input bit poke);
      @(posedge clk); #1;
      bus_mhz = 8'(f); mode_m = 4'(mm); mode_s = 4'(ms); prefetch_en = pf;
      model(f, mm, ms, pf);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      pending = 1;
      if (poke) begin
         // R9: a start pulse in mid-run must not queue a second request
         repeat (30) @(posedge clk);
         #1 start = 1'b1;
         @(posedge clk); #1 start = 1'b0;
      end
      while (pending) @(posedge clk);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); in_reset = 0;
      run(33, 4, 4, 1'b1, 1'b0);    // R1 nominal fast mode
      run(33, 0, 4, 1'b0, 1'b0);    // R5 master dominates address
      run(33, 4, 0, 1'b1, 1'b0);    // R5 slave dominates address
      run(25, 3, 15, 1'b1, 1'b0);   // R4 absent slave
      run(40, 15, 2, 1'b0, 1'b0);   // R4 absent master
      run(50, 15, 15, 1'b1, 1'b0);  // R4 both absent
      run(255, 0, 1, 1'b1, 1'b0);   // R3 upper clamps
      run(1, 2, 3, 1'b0, 1'b0);     // R3 lower recovery clamp
      run(0, 1, 4, 1'b1, 1'b0);     // R3 zero counts
      run(33, 7, 12, 1'b0, 1'b0);   // R8 out-of-range modes
      run(66, 1, 2, 1'b1, 1'b1);    // R9 start while busy ignored
      for (int m = 0; m < 5; m++) run(20 + 20 * m, m, 4 - m, m[0], 1'b0);  // R2 R8 sweep
      repeat (40) @(posedge clk);   // R9 no stray done
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule